// File: doc/BRIEF.md
# Elastic Rate Match FIFO

This block absorbs a small frequency offset between a recovered receive clock and the local clock of a serial receive path. Nine-bit symbols (a control flag above an 8-bit byte) are written on the recovered clock and read back one per local clock cycle. The fill level is kept near the middle by editing runs of a configurable skip symbol. On the write side a skip copy is left out when the buffer runs high. On the read side a skip copy is repeated when the buffer runs low. Data symbols are never edited.

When the buffer cannot take a symbol, that symbol is lost and the loss is reported on the read side, together with the first symbol that follows it. When the reader runs dry, the block sends a fixed filler control code and raises a flag. It keeps sending fillers until the buffer is half full again. Write and read positions cross between the clock domains as Gray codes through two-stage synchronisers. Each domain has its own active-low reset.

Top module: `elastic_skip_fifo`

## Requirements
- R1: A symbol is a skip only when all 9 bits (bit 8 = control flag, bits 7:0 = byte) equal `skip_sym`. A data symbol with the same byte but a clear control flag passes unchanged.
- R2: Data symbols leave in write order with no loss, duplication or change when neither overflow nor underflow occurs.
- R3: With 12 or more of the 16 entries occupied, a skip may be left out on the write side. A cluster (a run of consecutive skips ended by any other symbol) loses at most 4 copies and always keeps at least one.
- R4: With 4 or fewer entries occupied, the skip at the head may be output again without consuming it. A cluster gains at most 4 copies, and only while fewer than 5 of its skips have been output. No skip is ever output where none was written.
- R5: A symbol written while all 16 entries are occupied is discarded. `rd_full` pulses with the first stored symbol output after the loss, and never with a symbol that follows no loss.
- R6: When the reader finds no stored symbol, it outputs 9'h1FE in the next cycle with `rd_empty` high for that one cycle. It then outputs 9'h1FE with `rd_empty` low until at least 8 entries are stored again, and all earlier stored symbols have been output before the first filler.
- R7: After reset, `rd_valid`, `rd_full` and `rd_empty` are low. `rd_valid` rises with the first stored symbol once 8 entries are present, and then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_valid | input | 1 | A symbol is presented this write cycle |
| wr_sym | input | 9 | Written symbol: control flag and byte |
| skip_sym | input | 9 | Skip symbol to match, held static |
| rd_clk | input | 1 | Local read clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_valid | output | 1 | Output stream has started |
| rd_sym | output | 9 | Output symbol |
| rd_full | output | 1 | A symbol was lost just before this one |
| rd_empty | output | 1 | First filler of an underflow |

## Verification
The assertions assume that `skip_sym` is static, that it differs from the filler code 9'h1FE, and that written data never equals the filler code. The bench keeps to this by writing data with the control flag clear, an incrementing byte and a fixed skip of 9'h1BC. It writes skip clusters of known length after every sixteenth data byte. The checks compare run lengths and byte gaps against these known values. The write clock period is moved slightly above and below the read clock period to force deletions and insertions. A large speed-up forces loss, and a stop in writing forces starvation.

// File: rtl/elastic_skip_fifo.sv
module elastic_skip_fifo #(
  parameter int AW        = 4,
  parameter int HI_MARK   = 12,
  parameter int LO_MARK   = 4,
  parameter int MAX_EDIT  = 4,
  parameter int RUN_LIMIT = 5
) (
  input  logic       wr_clk,
  input  logic       wr_rst_n,
  input  logic       wr_valid,
  input  logic [8:0] wr_sym,
  input  logic [8:0] skip_sym,
  input  logic       rd_clk,
  input  logic       rd_rst_n,
  output logic       rd_valid,
  output logic [8:0] rd_sym,
  output logic       rd_full,
  output logic       rd_empty
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int EW = $clog2(MAX_EDIT + 1);
  localparam int RW = $clog2(RUN_LIMIT + 1);
  localparam logic [PW-1:0] FULL_L = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_L = PW'(DEPTH / 2);
  localparam logic [PW-1:0] HI_L = PW'(HI_MARK);
  localparam logic [PW-1:0] LO_L = PW'(LO_MARK);
  localparam logic [EW-1:0] EDIT_L = EW'(MAX_EDIT);
  localparam logic [RW-1:0] RUN_L = RW'(RUN_LIMIT);
  localparam logic [8:0] FILL = 9'h1FE;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return (b >> 1) ^ b;
  endfunction

  logic [9:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wptr, wgray, rg1, rg2, w_occ;
  logic [EW-1:0] del_cnt;
  logic          w_kept, pend_drop;
  logic          w_skip, w_del, w_full, w_commit;

  assign w_occ    = wptr - g2b(rg2);
  assign w_skip   = wr_sym == skip_sym;
  assign w_full   = w_occ == FULL_L;
  assign w_del    = wr_valid && w_skip && w_kept && w_occ >= HI_L && del_cnt < EDIT_L;
  assign w_commit = wr_valid && !w_del && !w_full;

  always_ff @(posedge wr_clk)
    if (w_commit) mem[wptr[AW-1:0]] <= {pend_drop, wr_sym};

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wptr <= '0; wgray <= '0; rg1 <= '0; rg2 <= '0;
      del_cnt <= '0; w_kept <= 1'b0; pend_drop <= 1'b0;
    end else begin
      rg1 <= rgray; rg2 <= rg1;
      if (w_commit) begin
        wptr <= wptr + 1'b1;
        wgray <= b2g(wptr + 1'b1);
        pend_drop <= 1'b0;
      end else if (wr_valid && !w_del) begin
        pend_drop <= 1'b1;
      end
      if (wr_valid) begin
        if (!w_skip) begin
          del_cnt <= '0; w_kept <= 1'b0;
        end else if (w_del) begin
          del_cnt <= del_cnt + 1'b1;
        end else if (w_commit) begin
          w_kept <= 1'b1;
        end
      end
    end

  // read domain
  logic [PW-1:0] rptr, rgray, wg1, wg2, r_occ;
  logic [EW-1:0] ins_cnt;
  logic [RW-1:0] r_run;
  logic          starve, r_skip, r_ins;
  logic [9:0]    head;

  assign r_occ  = g2b(wg2) - rptr;
  assign head   = mem[rptr[AW-1:0]];
  assign r_skip = head[8:0] == skip_sym;
  assign r_ins  = r_skip && !head[9] && r_occ <= LO_L && ins_cnt < EDIT_L && r_run < RUN_L;

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      wg1 <= '0; wg2 <= '0; rptr <= '0; rgray <= '0;
      starve <= 1'b1; rd_valid <= 1'b0; rd_sym <= FILL;
      rd_full <= 1'b0; rd_empty <= 1'b0; ins_cnt <= '0; r_run <= '0;
    end else begin
      wg1 <= wgray; wg2 <= wg1;
      rd_full <= 1'b0;
      rd_empty <= 1'b0;
      if (starve) begin
        rd_sym <= FILL;
        if (r_occ >= HALF_L) starve <= 1'b0;
      end else if (r_occ == '0) begin
        rd_sym <= FILL;
        rd_empty <= 1'b1;
        starve <= 1'b1;
      end else begin
        rd_valid <= 1'b1;
        rd_sym <= head[8:0];
        if (r_ins) begin
          ins_cnt <= ins_cnt + 1'b1;
          if (r_run != RUN_L) r_run <= r_run + 1'b1;
        end else begin
          rptr <= rptr + 1'b1;
          rgray <= b2g(rptr + 1'b1);
          rd_full <= head[9];
          if (r_skip) begin
            if (r_run != RUN_L) r_run <= r_run + 1'b1;
          end else begin
            r_run <= '0; ins_cnt <= '0;
          end
        end
      end
    end
endmodule

// File: rtl/elastic_skip_fifo_chk.sv
module elastic_skip_fifo_chk #(
  parameter int AW = 4
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          wr_valid,
  input logic [8:0]    wr_sym,
  input logic [8:0]    skip_sym,
  input logic [AW:0]   wptr,
  input logic [AW:0]   wgray,
  input logic [AW:0]   w_occ,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_valid,
  input logic [8:0]    rd_sym,
  input logic          rd_full,
  input logic          rd_empty,
  input logic [AW:0]   rptr,
  input logic [AW:0]   rgray
);
  localparam logic [AW:0] FULL_L = (AW+1)'(1 << AW);

  AST_NO_OVERWRITE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_valid && w_occ == FULL_L) |=> $stable(wptr)); // R5
  AST_DEL_SKIP_ONLY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_valid && w_occ != FULL_L) |=> (wptr != $past(wptr)) || ($past(wr_sym) == $past(skip_sym))); // R3
  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R2
  AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R2
  AST_REPEAT_IS_SKIP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    ($stable(rptr) && rd_valid && rd_sym != 9'h1FE) |-> rd_sym == skip_sym); // R4
  AST_EMPTY_FILL: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |-> (rd_valid && rd_sym == 9'h1FE)); // R6
  AST_EMPTY_ONCE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |=> !rd_empty); // R6
  AST_FULL_VALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_full |-> (rd_valid && rd_sym != 9'h1FE)); // R5
endmodule

bind elastic_skip_fifo elastic_skip_fifo_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_sym(wr_sym),
  .skip_sym(skip_sym), .wptr(wptr), .wgray(wgray), .w_occ(w_occ),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid), .rd_sym(rd_sym),
  .rd_full(rd_full), .rd_empty(rd_empty), .rptr(rptr), .rgray(rgray)
);

// File: tb/elastic_skip_fifo_bench.sv
`timescale 1ns/1ps
module elastic_skip_fifo_bench;
  localparam logic [8:0] SKIP = 9'h1BC;
  localparam logic [8:0] FILL = 9'h1FE;

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0, wr_valid = 0;
  logic [8:0] wr_sym = '0, skip_sym = SKIP;
  logic rd_valid, rd_full, rd_empty;
  logic [8:0] rd_sym;
  real wr_half = 4.0;

  int errors = 0, checks = 0;
  bit gen_on = 0, skips_on = 1;
  logic [7:0] cnt = 0, last_data = 0;
  int clu_left = 0;
  logic [3:0] exp_len [256];

  bit have_prev = 0, prev_fill = 0;
  logic [7:0] prev_d = 0;
  int run = 0, del_tot = 0, ins_tot = 0, fill_events = 0, drops_seen = 0;

  elastic_skip_fifo u_elastic_skip_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_sym(wr_sym),
    .skip_sym(skip_sym), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
    .rd_sym(rd_sym), .rd_full(rd_full), .rd_empty(rd_empty)
  );

  initial forever #4 rd_clk = ~rd_clk;
  initial forever #(wr_half) wr_clk = ~wr_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // writer: incrementing data bytes, a skip cluster after every byte ending in F
  initial forever begin
    @(negedge wr_clk);
    if (clu_left > 0) begin
      wr_sym = SKIP; wr_valid = 1; clu_left--;
    end else if (gen_on) begin
      wr_sym = {1'b0, cnt}; wr_valid = 1; last_data = cnt;
      if (skips_on && cnt[3:0] == 4'hF) begin
        clu_left = 1 + int'(cnt[6:4]);
        exp_len[cnt] = 4'(clu_left);
      end else begin
        exp_len[cnt] = 4'd0;
      end
      cnt++;
    end else begin
      wr_valid = 0;
    end
  end

  // reader monitor
  initial forever begin
    @(negedge rd_clk);
    if (rd_rst_n && rd_valid) begin
      if (rd_sym == FILL) begin
        chk(rd_empty == !prev_fill, "R6 empty flag on first filler only", int'(rd_empty), int'(!prev_fill));
        if (rd_empty) fill_events++;
        prev_fill = 1;
      end else if (rd_sym == SKIP) begin
        chk(!rd_full && !rd_empty, "R5 no flag on skip", int'({rd_full, rd_empty}), 0);
        run++;
        prev_fill = 0;
      end else begin
        logic [7:0] d, gap;
        int len;
        d = rd_sym[7:0];
        chk(!rd_empty && !rd_sym[8], "R2 data symbol intact", int'(rd_sym), int'({1'b0, d}));
        if (have_prev) begin
          gap = d - prev_d;
          if (rd_full) begin
            drops_seen++;
            chk(gap >= 2, "R5 full flag marks a lost symbol", int'(gap), 2);
          end else if (d == 8'hBC) begin
            chk(gap == 1, "R1 byte equal to skip but flag clear kept", int'(gap), 1);
          end else begin
            chk(gap == 1, "R2 data order without loss", int'(gap), 1);
          end
          len = int'(exp_len[prev_d]);
          if (len == 0) begin
            chk(run == 0, "R4 no skip where none written", run, 0);
          end else begin
            chk(run >= 1 && run + 4 >= len, "R3 deletion bound", run, len);
            chk(run <= len + 4, "R4 insertion bound", run, len);
            if (run < len) del_tot += len - run;
            else ins_tot += run - len;
          end
        end
        prev_d = d; have_prev = 1; run = 0; prev_fill = 0;
      end
    end
  end

  initial begin
    #1000000;
    chk(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge rd_clk);
    chk(!rd_valid && !rd_full && !rd_empty, "R7 outputs low in reset", int'({rd_valid, rd_full, rd_empty}), 0);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (10) @(negedge rd_clk);
    chk(!rd_valid, "R7 no output without writes", int'(rd_valid), 0);
    gen_on = 1;
    repeat (6) @(negedge rd_clk);
    chk(!rd_valid, "R7 no output before half full", int'(rd_valid), 0);
    repeat (30) @(negedge rd_clk);
    chk(rd_valid, "R7 output starts after priming", int'(rd_valid), 1);
    repeat (400) @(negedge rd_clk);
    wr_half = 3.8;
    repeat (1500) @(negedge rd_clk);
    chk(del_tot > 0, "R3 skips removed under fast writes", del_tot, 1);
    wr_half = 4.2;
    repeat (1500) @(negedge rd_clk);
    chk(ins_tot > 0, "R4 skips added under slow writes", ins_tot, 1);
    chk(fill_events == 0 && drops_seen == 0, "R2 no loss or starvation at near-equal rates", fill_events + drops_seen, 0);
    wr_half = 4.0;
    skips_on = 0;
    repeat (50) @(negedge rd_clk);
    wr_half = 3.0;
    repeat (400) @(negedge rd_clk);
    chk(drops_seen > 0, "R5 overflow reported", drops_seen, 1);
    wr_half = 4.0;
    repeat (20) @(negedge rd_clk);
    gen_on = 0;
    repeat (100) @(negedge rd_clk);
    chk(fill_events == 1, "R6 one underflow event", fill_events, 1);
    chk(rd_valid && rd_sym == FILL, "R6 filler while starved", int'(rd_sym), int'(FILL));
    chk(prev_d == last_data, "R6 stored symbols all output before filler", int'(prev_d), int'(last_data));
    skips_on = 1;
    gen_on = 1;
    repeat (400) @(negedge rd_clk);
    chk(fill_events == 1, "R6 refill without new underflow", fill_events, 1);
    chk(rd_valid && rd_sym != FILL, "R7 valid stays high after refill", int'(rd_sym), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule